// File: doc/BRIEF.md
# Segment-Register Address Translation Frontend

This block turns a 32-bit effective address into a real address by way of a file of sixteen 32-bit segment descriptors. The top four address bits pick a descriptor. From that descriptor and the access attributes the block works out a protection key, a no-execute flag, a direct-store flag and a 24-bit segment identifier. It then forms two page-table-group byte offsets and a compare tag. A request to a normal segment is resolved by at most two probes on a request/acknowledge port to an external page-table searcher: the primary group first, then the secondary group. A request to a direct-store segment is resolved inside the block, without a probe.

A request is accepted in any cycle in which the block is idle. The outcome appears on a result code, a real address and a 3-bit permission mask, marked by a one-cycle done strobe. Descriptors are loaded through a single write port. The hash-table mask is a static configuration input.

Top module: `seg_xlate`

## Requirements
- R1: Address bits 31:28 select one of sixteen descriptors. In a descriptor, bit 31 marks a direct-store segment, bit 28 marks no-execute, and bits 23:0 hold the segment identifier. A segment with bit 31 clear is resolved through probes. A segment with bit 31 set never issues a probe.
- R2: The key is descriptor bit 29 for a problem-state access (`req_pr`=1) and descriptor bit 30 for a supervisor access. The key is sent on `lk_key` with each probe and is used by the direct-store rules.
- R3: The page index is address bits 27:12. The 32-bit primary hash is the segment identifier XOR the zero-extended page index, and the secondary hash is its full 32-bit complement. Each probe offset is (hash × 8 × PTE_BYTES) AND `tbl_mask`.
- R4: The compare tag on `lk_tag` is the segment identifier shifted left by 7, ORed with page index bits 15:10.
- R5: An instruction fetch (type 1) to a normal no-execute segment finishes with the no-access code (4) and issues no probe.
- R6: The primary probe (`lk_sec`=0) is issued first. The secondary probe (`lk_sec`=1) follows only when the primary result is neither success (0) nor direct-store success (1). The final code is the secondary code, except when the secondary code is not-found (2); in that case the primary code stands. Request fields stay stable while `lk_req` is high and `lk_ack` is low. `lk_wr` and `lk_type` echo the access.
- R7: On a success code (0 or 1) from a probe, `res_raddr` and `res_prot` come from that probe's response. Every failing result (codes 2 to 6) reports a real address of all ones and a permission mask of zero.
- R8: A direct-store segment whose bits 28:20 equal 0x07F maps to real address {descriptor bits 3:0, address bits 27:0}. It returns code 0 with permission 3'b111 (bit0 read, bit1 write, bit2 execute) for every access type, privilege and direction.
- R9: In any other direct-store segment, access types 1 (fetch), 2 (float), 3 (reservation), 5 (external control), 6 and 7 give the invalid-access code (5). Type 4 (cache management) gives code 0 with the real address equal to the effective address and permission 0.
- R10: An integer access (type 0) to such a segment succeeds with code 1, the real address equal to the effective address and permission 0 when it is a write with key 1 or a read with key 0. Otherwise it gives the protection code (3).
- R11: After reset `done`, `busy` and `lk_req` are low. `done` is high for exactly one cycle per accepted request. A `req_valid` that arrives while `busy` is high is ignored.
- R12: A write on `seg_we` replaces descriptor `seg_widx`, and later translations through that index use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Descriptor write enable |
| seg_widx | input | 4 | Descriptor index to write |
| seg_wdata | input | 32 | Descriptor write data |
| tbl_mask | input | 32 | Hash-table byte-offset mask |
| req_valid | input | 1 | Translation request |
| req_ea | input | 32 | Effective address |
| req_pr | input | 1 | 1 = problem state, 0 = supervisor |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_type | input | 3 | Access type: 0 int, 1 fetch, 2 float, 3 reservation, 4 cache, 5 external |
| busy | output | 1 | Probe sequence in progress |
| lk_req | output | 1 | Probe request to the searcher |
| lk_sec | output | 1 | 1 = secondary group probe |
| lk_off | output | 32 | Page-table-group byte offset |
| lk_tag | output | 32 | Compare tag |
| lk_key | output | 1 | Protection key |
| lk_wr | output | 1 | Access direction |
| lk_type | output | 3 | Access type |
| lk_ack | input | 1 | Probe response valid |
| lk_code | input | 3 | Probe result code |
| lk_raddr | input | 32 | Probe real address |
| lk_prot | input | 3 | Probe permission mask |
| done | output | 1 | Result strobe |
| res_code | output | 3 | 0 ok, 1 direct-store ok, 2 not found, 3 protection, 4 no access, 5 invalid, 6 segment miss |
| res_raddr | output | 32 | Real address |
| res_prot | output | 3 | Permission mask |

## Verification
The hardest case to reach is the merge of the two probe results. A failing primary code must survive a not-found secondary, and must be overridden by any other secondary code. This outcome depends entirely on what the external searcher returns. The bench therefore plays the searcher itself and sweeps all 49 pairs of primary and secondary codes on one address, recording each probe's offset, tag and flags. A second hard case is a request that arrives while a probe sequence is in flight. The bench reaches it by pulsing a conflicting request during the searcher's response latency and then confirming that the result and the probe count belong only to the first request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int EA_W        = 32;
    localparam int SEL_W       = 4;
    localparam int NSEG        = 1 << SEL_W;
    localparam int VSID_W      = 24;
    localparam int PIDX_LO     = 12;
    localparam int PIDX_W      = 16;
    localparam int TAG_VSHIFT  = 7;
    localparam int TAG_PSHIFT  = 10;
    localparam int DS_BIT      = 31;
    localparam int KS_BIT      = 30;
    localparam int KP_BIT      = 29;
    localparam int NX_BIT      = 28;
    localparam int BUID_HI     = 28;
    localparam int BUID_LO     = 20;
    localparam int BUID_W      = BUID_HI - BUID_LO + 1;
    localparam logic [BUID_W-1:0] MF_BUID = 9'h07F;

    localparam logic [2:0] ACC_INT   = 3'd0;
    localparam logic [2:0] ACC_CODE  = 3'd1;
    localparam logic [2:0] ACC_FLOAT = 3'd2;
    localparam logic [2:0] ACC_RES   = 3'd3;
    localparam logic [2:0] ACC_CACHE = 3'd4;
    localparam logic [2:0] ACC_EXT   = 3'd5;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_DS_OK    = 3'd1,
        RES_NOTFOUND = 3'd2,
        RES_PROT     = 3'd3,
        RES_NOACC    = 3'd4,
        RES_INVAL    = 3'd5,
        RES_SEGMISS  = 3'd6
    } res_code_e;

    typedef struct packed {
        logic              ds;
        logic              nx;
        logic              key;
        logic [BUID_W-1:0] buid;
        logic [3:0]        seg_hi;
    } seg_info_t;

    function automatic logic code_fails(input logic [2:0] c);
        return !(c == RES_OK || c == RES_DS_OK);
    endfunction

endpackage

// File: rtl/seg_xlate_regfile.sv
module seg_xlate_regfile
    import seg_xlate_pkg::*;
#(
    parameter int N = NSEG,
    parameter int W = EA_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[ridx];

    // R12: one cycle after a write the entry reads back the written value
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ridx == widx) |=> (rdata == $past(wdata))) else $error("write lost"); // R12

endmodule

// File: rtl/seg_xlate_decode.sv
module seg_xlate_decode
    import seg_xlate_pkg::*;
#(
    parameter int PTE_BYTES = 8,
    localparam int OFF_SHIFT = $clog2(8 * PTE_BYTES)
) (
    input  logic [EA_W-1:0]   sr,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              pr,
    input  logic [EA_W-1:0]   tbl_mask,
    output seg_info_t         info,
    output logic [EA_W-1:0]   pri_off,
    output logic [EA_W-1:0]   sec_off,
    output logic [EA_W-1:0]   tag
);

    logic [VSID_W-1:0] vsid;
    logic [EA_W-1:0]   hash;

    always_comb begin
        vsid        = sr[VSID_W-1:0];
        hash        = {{(EA_W-VSID_W){1'b0}}, vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx}};
        pri_off     = (hash << OFF_SHIFT) & tbl_mask;
        sec_off     = ((~hash) << OFF_SHIFT) & tbl_mask;
        tag         = ({{(EA_W-VSID_W){1'b0}}, vsid} << TAG_VSHIFT)
                    | {{(EA_W-PIDX_W){1'b0}}, pidx >> TAG_PSHIFT};
        info.ds     = sr[DS_BIT];
        info.nx     = sr[NX_BIT];
        info.key    = pr ? sr[KP_BIT] : sr[KS_BIT];
        info.buid   = sr[BUID_HI:BUID_LO];
        info.seg_hi = sr[3:0];
    end

    // R3: the two probe offsets differ wherever the mask keeps a hash bit
    always_comb begin
        if (tbl_mask == {EA_W{1'b1}}) begin
            AST_HASH_PAIR: assert ((pri_off ^ sec_off) == ({EA_W{1'b1}} << OFF_SHIFT)) else $error("hash pair"); // R3
        end
    end

endmodule

// File: rtl/seg_xlate_dspath.sv
module seg_xlate_dspath
    import seg_xlate_pkg::*;
(
    input  seg_info_t       info,
    input  logic [EA_W-1:0] ea,
    input  logic            wr,
    input  logic [2:0]      typ,
    output res_code_e       code,
    output logic [EA_W-1:0] raddr,
    output logic [2:0]      prot
);

    always_comb begin
        code  = RES_INVAL;
        raddr = '1;
        prot  = '0;
        if (info.buid == MF_BUID) begin
            code  = RES_OK;
            raddr = {info.seg_hi, ea[EA_W-5:0]};
            prot  = 3'b111;
        end else begin
            case (typ)
                ACC_INT: begin
                    if (wr ? info.key : !info.key) begin
                        code  = RES_DS_OK;
                        raddr = ea;
                    end else begin
                        code  = RES_PROT;
                    end
                end
                ACC_CACHE: begin
                    code  = RES_OK;
                    raddr = ea;
                end
                default: begin
                    code  = RES_INVAL;
                end
            endcase
        end
    end

    // R9: a fetch through the direct-store path never succeeds outside the window
    always_comb begin
        if (typ == ACC_CODE && info.buid != MF_BUID) begin
            AST_DS_NO_FETCH: assert (code == RES_INVAL) else $error("ds fetch"); // R9
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int PTE_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seg_we,
    input  logic [3:0]  seg_widx,
    input  logic [31:0] seg_wdata,
    input  logic [31:0] tbl_mask,
    input  logic        req_valid,
    input  logic [31:0] req_ea,
    input  logic        req_pr,
    input  logic        req_wr,
    input  logic [2:0]  req_type,
    output logic        busy,
    output logic        lk_req,
    output logic        lk_sec,
    output logic [31:0] lk_off,
    output logic [31:0] lk_tag,
    output logic        lk_key,
    output logic        lk_wr,
    output logic [2:0]  lk_type,
    input  logic        lk_ack,
    input  logic [2:0]  lk_code,
    input  logic [31:0] lk_raddr,
    input  logic [2:0]  lk_prot,
    output logic        done,
    output logic [2:0]  res_code,
    output logic [31:0] res_raddr,
    output logic [2:0]  res_prot
);

    typedef enum logic [1:0] {ST_IDLE, ST_PRI, ST_SEC} st_e;

    typedef struct packed {
        st_e             st;
        logic [EA_W-1:0] sec_off;
        res_code_e       pcode;
        logic            lk_req;
        logic            lk_sec;
        logic [EA_W-1:0] lk_off;
        logic [EA_W-1:0] lk_tag;
        logic            lk_key;
        logic            lk_wr;
        logic [2:0]      lk_type;
        logic            done;
        res_code_e       code;
        logic [EA_W-1:0] raddr;
        logic [2:0]      prot;
    } state_t;

    state_t r_q, r_d;

    logic [EA_W-1:0] sr;
    seg_info_t       info;
    logic [EA_W-1:0] pri_off, sec_off, tag;
    res_code_e       ds_code;
    logic [EA_W-1:0] ds_raddr;
    logic [2:0]      ds_prot;

    seg_xlate_regfile #(.N(NSEG), .W(EA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .widx  (seg_widx),
        .wdata (seg_wdata),
        .ridx  (req_ea[EA_W-1 -: SEL_W]),
        .rdata (sr)
    );

    seg_xlate_decode #(.PTE_BYTES(PTE_BYTES)) u_dec (
        .sr       (sr),
        .pidx     (req_ea[PIDX_LO +: PIDX_W]),
        .pr       (req_pr),
        .tbl_mask (tbl_mask),
        .info     (info),
        .pri_off  (pri_off),
        .sec_off  (sec_off),
        .tag      (tag)
    );

    seg_xlate_dspath u_ds (
        .info  (info),
        .ea    (req_ea),
        .wr    (req_wr),
        .typ   (req_type),
        .code  (ds_code),
        .raddr (ds_raddr),
        .prot  (ds_prot)
    );

    always_comb begin
        res_code_e fin;
        fin    = RES_OK;
        r_d    = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (info.ds) begin
                        r_d.done  = 1'b1;
                        r_d.code  = ds_code;
                        r_d.raddr = ds_raddr;
                        r_d.prot  = ds_prot;
                    end else if (req_type == ACC_CODE && info.nx) begin
                        r_d.done  = 1'b1;
                        r_d.code  = RES_NOACC;
                        r_d.raddr = '1;
                        r_d.prot  = '0;
                    end else begin
                        r_d.st      = ST_PRI;
                        r_d.raddr   = '1;
                        r_d.lk_req  = 1'b1;
                        r_d.lk_sec  = 1'b0;
                        r_d.lk_off  = pri_off;
                        r_d.sec_off = sec_off;
                        r_d.lk_tag  = tag;
                        r_d.lk_key  = info.key;
                        r_d.lk_wr   = req_wr;
                        r_d.lk_type = req_type;
                    end
                end
            end
            ST_PRI: begin
                if (lk_ack) begin
                    if (code_fails(lk_code)) begin
                        r_d.st     = ST_SEC;
                        r_d.pcode  = res_code_e'(lk_code);
                        r_d.lk_sec = 1'b1;
                        r_d.lk_off = r_q.sec_off;
                    end else begin
                        r_d.st     = ST_IDLE;
                        r_d.lk_req = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.code   = res_code_e'(lk_code);
                        r_d.raddr  = lk_raddr;
                        r_d.prot   = lk_prot;
                    end
                end
            end
            ST_SEC: begin
                if (lk_ack) begin
                    fin = (lk_code == RES_NOTFOUND) ? r_q.pcode : res_code_e'(lk_code);
                    r_d.st     = ST_IDLE;
                    r_d.lk_req = 1'b0;
                    r_d.lk_sec = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.code   = fin;
                    if (code_fails(fin)) begin
                        r_d.raddr = '1;
                        r_d.prot  = '0;
                    end else begin
                        r_d.raddr = lk_raddr;
                        r_d.prot  = lk_prot;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign lk_req    = r_q.lk_req;
    assign lk_sec    = r_q.lk_sec;
    assign lk_off    = r_q.lk_off;
    assign lk_tag    = r_q.lk_tag;
    assign lk_key    = r_q.lk_key;
    assign lk_wr     = r_q.lk_wr;
    assign lk_type   = r_q.lk_type;
    assign done      = r_q.done;
    assign res_code  = r_q.code;
    assign res_raddr = r_q.raddr;
    assign res_prot  = r_q.prot;

    AST_NX_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !sr[DS_BIT] && sr[NX_BIT] && req_type == ACC_CODE)
        |=> (done && res_code == RES_NOACC && !lk_req)) else $error("nx fetch"); // R5
    AST_FAIL_RADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && code_fails(res_code)) |-> (res_raddr == '1 && res_prot == '0)) else $error("fail addr"); // R7
    AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_ack) |=> (lk_req && $stable(lk_off) && $stable(lk_sec))) else $error("probe moved"); // R6
    AST_NO_SEC_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_ack && !lk_sec && !code_fails(lk_code)) |=> (!lk_req && done)) else $error("extra probe"); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !lk_req)) else $error("done busy"); // R11

endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_widx = '0;
    logic [31:0] seg_wdata = '0;
    logic [31:0] tbl_mask = 32'h000F_FFC0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_pr = 1'b0;
    logic        req_wr = 1'b0;
    logic [2:0]  req_type = '0;
    logic        busy, lk_req, lk_sec, lk_key, lk_wr, done;
    logic [31:0] lk_off, lk_tag, res_raddr;
    logic [2:0]  lk_type, res_code, res_prot;
    logic        lk_ack = 1'b0;
    logic [2:0]  lk_code = '0;
    logic [31:0] lk_raddr = '0;
    logic [2:0]  lk_prot = '0;

    int checks = 0;
    int errors = 0;

    seg_xlate dut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_widx(seg_widx), .seg_wdata(seg_wdata),
        .tbl_mask(tbl_mask), .req_valid(req_valid), .req_ea(req_ea), .req_pr(req_pr),
        .req_wr(req_wr), .req_type(req_type), .busy(busy), .lk_req(lk_req), .lk_sec(lk_sec),
        .lk_off(lk_off), .lk_tag(lk_tag), .lk_key(lk_key), .lk_wr(lk_wr), .lk_type(lk_type),
        .lk_ack(lk_ack), .lk_code(lk_code), .lk_raddr(lk_raddr), .lk_prot(lk_prot),
        .done(done), .res_code(res_code), .res_raddr(res_raddr), .res_prot(res_prot)
    );

    always #4 clk = ~clk;

    logic [31:0] segs [16];
    logic [2:0]  p_code = 3'd2, s_code = 3'd0;
    int          nreq = 0;
    int          lat_cnt = 0;
    logic [31:0] cap_off [2];
    logic [31:0] cap_tag [2];
    logic        cap_key [2];
    logic        cap_wr  [2];
    logic        cap_sec [2];
    logic [2:0]  cap_type [2];

    // searcher model
    always @(negedge clk) begin
        if (lk_ack) begin
            lk_ack = 1'b0;
        end else if (lk_req) begin
            if (lat_cnt == LAT - 1) begin
                lat_cnt  = 0;
                lk_ack   = 1'b1;
                lk_code  = lk_sec ? s_code : p_code;
                lk_raddr = lk_sec ? (32'h5000_0000 ^ lk_off) : (32'hA000_0000 ^ lk_off);
                lk_prot  = lk_sec ? 3'b110 : 3'b011;
                if (nreq < 2) begin
                    cap_off[nreq]  = lk_off;
                    cap_tag[nreq]  = lk_tag;
                    cap_key[nreq]  = lk_key;
                    cap_wr[nreq]   = lk_wr;
                    cap_sec[nreq]  = lk_sec;
                    cap_type[nreq] = lk_type;
                end
                nreq++;
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic bit fails(input logic [2:0] c);
        return !(c == 3'd0 || c == 3'd1);
    endfunction

    function automatic logic [31:0] seg_val(input int k);
        logic [31:0] v;
        logic [3:0]  kb;
        kb = 4'(k);
        v = {kb, 4'h5, 24'(k * 24'h1F35B + 24'h0A5C3)};
        if (k == 8 || k == 12) v[27:20] = 8'h7F;
        return v;
    endfunction

    task automatic write_seg(input int k, input logic [31:0] v);
        @(negedge clk);
        seg_we = 1'b1; seg_widx = 4'(k); seg_wdata = v;
        @(negedge clk);
        seg_we = 1'b0;
        segs[k] = v;
    endtask

    task automatic run_one(input logic [31:0] ea, input bit pr, input bit wr, input logic [2:0] typ,
                           input logic [2:0] pc, input logic [2:0] sc, input bit intrude);
        logic [31:0] sr, h, poff, soff, tagv, e_raddr;
        logic [2:0]  e_code, e_prot, fc;
        logic        key;
        int          e_nlk, t;
        string       rc, ra;
        sr   = segs[ea[31:28]];
        key  = pr ? sr[29] : sr[30];
        h    = {8'h0, sr[23:0] ^ {8'h0, ea[27:12]}};
        poff = (h << 6) & tbl_mask;
        soff = ((~h) << 6) & tbl_mask;
        tagv = ({8'h0, sr[23:0]} << 7) | {26'h0, ea[27:22]};
        e_nlk = 0; e_raddr = '1; e_prot = '0;
        if (sr[31]) begin
            if (sr[28:20] == 9'h07F) begin
                rc = "R8"; e_code = 3'd0; e_raddr = {sr[3:0], ea[27:0]}; e_prot = 3'b111;
            end else if (typ == 3'd0) begin
                rc = "R10";
                if (wr ? key : !key) begin e_code = 3'd1; e_raddr = ea; end else e_code = 3'd3;
            end else if (typ == 3'd4) begin
                rc = "R9"; e_code = 3'd0; e_raddr = ea;
            end else begin
                rc = "R9"; e_code = 3'd5;
            end
            ra = rc;
        end else if (typ == 3'd1 && sr[28]) begin
            rc = "R5"; ra = "R7"; e_code = 3'd4;
        end else begin
            rc = "R6"; ra = "R7";
            if (!fails(pc)) begin
                e_nlk = 1; e_code = pc; e_raddr = 32'hA000_0000 ^ poff; e_prot = 3'b011;
            end else begin
                e_nlk = 2; fc = (sc == 3'd2) ? pc : sc; e_code = fc;
                if (!fails(fc)) begin e_raddr = 32'h5000_0000 ^ soff; e_prot = 3'b110; end
            end
        end
        p_code = pc; s_code = sc;
        @(negedge clk);
        nreq = 0;
        req_valid = 1'b1; req_ea = ea; req_pr = pr; req_wr = wr; req_type = typ;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            chk(busy == 1'b1, "R11 busy", 32'(busy), 32'd1);
            req_valid = 1'b1; req_ea = ea ^ 32'h0F0F_F000; req_pr = !pr; req_wr = !wr; req_type = 3'd4;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R11 done", 32'(done), 32'd1);
        chk(res_code == e_code, rc, 32'(res_code), 32'(e_code));
        chk(res_raddr == e_raddr, ra, res_raddr, e_raddr);
        chk(res_prot == e_prot, ra, 32'(res_prot), 32'(e_prot));
        chk(nreq == e_nlk, "R1 probes", 32'(nreq), 32'(e_nlk));
        if (e_nlk >= 1 && nreq >= 1) begin
            chk(cap_off[0] == poff, "R3 pri", cap_off[0], poff);
            chk(cap_tag[0] == tagv, "R4", cap_tag[0], tagv);
            chk(cap_key[0] == key, "R2", 32'(cap_key[0]), 32'(key));
            chk(cap_wr[0] == wr && cap_type[0] == typ && !cap_sec[0], "R6 fields",
                {28'h0, cap_sec[0], cap_type[0]}, {29'h0, typ});
        end
        if (e_nlk == 2 && nreq == 2) begin
            chk(cap_off[1] == soff, "R3 sec", cap_off[1], soff);
            chk(cap_sec[1] == 1'b1, "R6 sec", 32'(cap_sec[1]), 32'd1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R11 pulse", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && lk_req == 1'b0, "R11 reset",
            {29'h0, done, busy, lk_req}, 32'h0);

        for (int k = 0; k < 16; k++) write_seg(k, seg_val(k));

        // R1 R2 R5 R8 R9 R10: sweep all segments, privileges, directions, types
        for (int k = 0; k < 16; k++)
            for (int pr = 0; pr < 2; pr++)
                for (int wr = 0; wr < 2; wr++)
                    for (int ty = 0; ty < 8; ty++)
                        run_one({4'(k), 28'(k * 32'h0123457 + ty * 32'h0011000 + pr * 32'h5000 + wr * 32'h80)},
                                pr[0], wr[0], 3'(ty), 3'd2, 3'd0, 1'b0);

        // R6 R7: every primary/secondary code pairing
        for (int pc = 0; pc < 7; pc++)
            for (int sc = 0; sc < 7; sc++)
                run_one(32'h2ABC_D123, 1'b0, 1'b1, 3'd0, 3'(pc), 3'(sc), 1'b0);

        // R3: full mask exposes the complemented upper hash bits
        tbl_mask = 32'hFFFF_FFFF;
        for (int i = 0; i < 8; i++)
            run_one({4'(i), 28'(i * 32'h0765_4321)}, i[0], i[1], 3'd2, 3'd3, 3'd2, 1'b0);
        tbl_mask = 32'h000F_FFC0;

        // R11: requests during a probe sequence are ignored
        for (int i = 0; i < 4; i++)
            run_one({4'(i), 28'h1234_000}, 1'b1, 1'b0, 3'd0, 3'd2, 3'(i), 1'b1);

        // R12: rewrite descriptors and translate through them
        write_seg(3, 32'h8000_0000 | 32'h2001_2345);
        run_one(32'h3000_4000, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0);
        write_seg(3, 32'h0000_ABCD);
        run_one(32'h3765_4000, 1'b1, 1'b1, 3'd5, 3'd0, 3'd0, 1'b0);
        write_seg(12, 32'hF7FA_BCD9);
        run_one(32'hC123_4567, 1'b1, 1'b0, 3'd1, 3'd0, 3'd0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule